// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a data cache built from a direct-mapped main array and a small fully associative victim buffer. Both are searched in the same cycle, so an access served from either one costs the same single cycle. Lines enter the victim buffer only when the main array displaces them. A hit in the victim buffer exchanges that line with the main-array line at the same index. A line is therefore held in at most one of the two structures, and the buffer acts as a tiny exclusive level behind the main array.

Writes follow a write-back, write-allocate policy. A modified line stays in the cache as it moves between the main array and the victim buffer. It reaches memory only when it is pushed out of a full victim buffer. The buffer keeps its entries in insertion order and drops the entry that was inserted earliest. When both structures miss, the requester is stalled. A whole line is fetched through a request/acknowledge handshake on the memory side, and any dirty line that must leave the buffer is written out first.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset no line is valid in either structure. The first access to any address misses. Right after reset `req_ready` is 1, while `resp_valid` and `mem_req_valid` are 0.
- R2: A word address holds, from bit 0 upward, an OFF_W-bit word offset, then an IDX_W-bit line index, then a TAG_W-bit tag. The line address on the memory side is the word address shifted right by OFF_W. Word k of a line occupies bits [k*WORD_W +: WORD_W] of the line bus.
- R3: An access that hits the main array is answered in the cycle after it is accepted, with `resp_hit`=1 and no memory request.
- R4: An access that misses the main array but hits the victim buffer is answered with the same one-cycle latency, with `resp_hit`=1 and no memory request. The two lines swap places.
- R5: A line is never valid in both the main array and the victim buffer at the same time.
- R6: An access that misses both structures drops `req_ready` in the following cycle and reads the whole line from memory. It is answered one cycle after the read acknowledge, with `resp_hit`=0 and the requested word.
- R7: On a miss, a valid line displaced from the main array is appended to the victim buffer as its newest entry. The valid entries of the buffer stay packed from entry 0 upward in insertion order.
- R8: When the victim buffer is full and a displaced line must enter it, the earliest inserted entry is dropped. If that entry is dirty, it is written to memory with its most recent data before the line read is issued.
- R9: A clean entry that is dropped, and a clean line at any time, causes no memory write.
- R10: Writes never go to memory directly. A write miss allocates the line, and a later read of any address returns the most recently written value or, if the address was never written, the memory contents.
- R11: While `mem_req_valid` is 1 and `mem_ack` is 0, the memory request stays valid and its address and direction do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | One-cycle pulse: request completed |
| resp_hit | output | 1 | Completed request was served without a refill |
| resp_rdata | output | WORD_W | Word read (meaningful for reads) |
| mem_req_valid | output | 1 | Memory transfer requested |
| mem_req_we | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | LA_W | Line address of the transfer |
| mem_wline | output | LINE_W | Line data for a writeback |
| mem_ack | input | 1 | One-cycle pulse: transfer done |
| mem_rline | input | LINE_W | Line data, valid with `mem_ack` on a read |

## Verification
The assertions assume that the memory side answers each request with a single-cycle `mem_ack` pulse and presents `mem_rline` in that same cycle. They also assume that `req_valid` is raised only while `req_ready` is 1. The bench drives one request at a time and drops `req_valid` right after the accepting edge. Its memory model acknowledges after a random delay of zero to two cycles and clears the pulse on the next cycle. Random addresses are kept within a space only a few times larger than the combined capacity, so swaps, full-buffer evictions and dirty writebacks all occur often.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_victim_match.sv
// Parallel tag compare across all victim entries.
module vc_victim_match #(
  parameter int N     = 4,
  parameter int LA_W  = 5,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [LA_W-1:0]  ent_laddr [N],
  input  logic [LA_W-1:0]  probe,
  output logic [N-1:0]     hit_vec,
  output logic             any_hit,
  output logic [SEL_W-1:0] hit_sel
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_laddr[g] == probe);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_sel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/vc_victim_store.sv
// Victim entries kept packed from entry 0 (oldest) upward.
module vc_victim_store #(
  parameter int N      = 4,
  parameter int LA_W   = 5,
  parameter int LINE_W = 32,
  parameter int SEL_W  = (N > 1) ? $clog2(N) : 1,
  parameter int CNT_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_swap,
  input  logic              do_fill,
  input  logic [SEL_W-1:0]  sel,
  input  logic              in_valid,
  input  logic [LA_W-1:0]   in_laddr,
  input  logic              in_dirty,
  input  logic [LINE_W-1:0] in_data,
  output logic [N-1:0]      ent_valid,
  output logic [N-1:0]      ent_dirty,
  output logic [LA_W-1:0]   ent_laddr [N],
  output logic [LINE_W-1:0] ent_data [N],
  output logic [CNT_W-1:0]  count
);
  logic [N-1:0]      n_valid, n_dirty;
  logic [LA_W-1:0]   n_laddr [N];
  logic [LINE_W-1:0] n_data [N];
  int                cnt;

  assign count = CNT_W'($countones(ent_valid));

  always_comb begin
    n_valid = ent_valid;
    n_dirty = ent_dirty;
    n_laddr = ent_laddr;
    n_data  = ent_data;
    cnt     = int'(count);
    if (do_swap) begin
      // remove the hit entry, close the gap, then append the displaced line
      for (int i = 0; i < N - 1; i++) begin
        if (i >= int'(sel)) begin
          n_valid[i] = ent_valid[i+1];
          n_dirty[i] = ent_dirty[i+1];
          n_laddr[i] = ent_laddr[i+1];
          n_data[i]  = ent_data[i+1];
        end
      end
      n_valid[N-1] = 1'b0;
      n_dirty[N-1] = 1'b0;
      if (in_valid) begin
        for (int i = 0; i < N; i++) begin
          if (i == cnt - 1) begin
            n_valid[i] = 1'b1;
            n_dirty[i] = in_dirty;
            n_laddr[i] = in_laddr;
            n_data[i]  = in_data;
          end
        end
      end
    end else if (do_fill && in_valid) begin
      if (cnt == N) begin
        for (int i = 0; i < N - 1; i++) begin
          n_valid[i] = ent_valid[i+1];
          n_dirty[i] = ent_dirty[i+1];
          n_laddr[i] = ent_laddr[i+1];
          n_data[i]  = ent_data[i+1];
        end
        n_valid[N-1] = 1'b1;
        n_dirty[N-1] = in_dirty;
        n_laddr[N-1] = in_laddr;
        n_data[N-1]  = in_data;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (i == cnt) begin
            n_valid[i] = 1'b1;
            n_dirty[i] = in_dirty;
            n_laddr[i] = in_laddr;
            n_data[i]  = in_data;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_dirty <= '0;
      for (int i = 0; i < N; i++) begin
        ent_laddr[i] <= '0;
        ent_data[i]  <= '0;
      end
    end else begin
      ent_valid <= n_valid;
      ent_dirty <= n_dirty;
      ent_laddr <= n_laddr;
      ent_data  <= n_data;
    end
  end
endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache
  import vc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int VICT_N = 4,
  parameter int ADDR_W = OFF_W + IDX_W + TAG_W,
  parameter int LINE_W = WORD_W * (1 << OFF_W),
  parameter int LA_W   = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [LA_W-1:0]   mem_req_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline
);
  localparam int LINES = 1 << IDX_W;
  localparam int SEL_W = (VICT_N > 1) ? $clog2(VICT_N) : 1;
  localparam int CNT_W = $clog2(VICT_N + 1);

  // ---- address and line arithmetic ----
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [LA_W-1:0] f_laddr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] off);
    return ln[int'(off)*WORD_W +: WORD_W];
  endfunction
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[int'(off)*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  // ---- main array ----
  logic [LINES-1:0]  m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag  [LINES];
  logic [LINE_W-1:0] m_data [LINES];

  // ---- control state ----
  vc_state_e         state;
  logic [ADDR_W-1:0] p_addr;
  logic              p_we;
  logic [WORD_W-1:0] p_wdata;

  // ---- victim buffer ----
  logic [VICT_N-1:0] v_valid, v_dirty, v_hitvec;
  logic [LA_W-1:0]   v_laddr [VICT_N];
  logic [LINE_W-1:0] v_data  [VICT_N];
  logic [CNT_W-1:0]  v_count;
  logic              v_any;
  logic [SEL_W-1:0]  v_sel;

  // ---- current access ----
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [WORD_W-1:0] cur_wdata;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;
  logic              main_hit, accept, need_wb;

  // ---- named events (observed by the checker) ----
  logic ev_main_hit, ev_vict_hit, ev_miss, ev_fill_done, ev_complete;

  logic [LINE_W-1:0] src_line, new_line;
  logic              src_dirty;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign cur_addr  = (state == ST_IDLE) ? req_addr  : p_addr;
  assign cur_we    = (state == ST_IDLE) ? req_we    : p_we;
  assign cur_wdata = (state == ST_IDLE) ? req_wdata : p_wdata;
  assign cur_idx   = f_idx(cur_addr);
  assign cur_tag   = f_tag(cur_addr);
  assign cur_off   = f_off(cur_addr);

  assign main_hit  = m_valid[cur_idx] && (m_tag[cur_idx] == cur_tag);

  vc_victim_match #(.N(VICT_N), .LA_W(LA_W), .SEL_W(SEL_W)) u_match (
    .ent_valid (v_valid),
    .ent_laddr (v_laddr),
    .probe     (f_laddr(cur_addr)),
    .hit_vec   (v_hitvec),
    .any_hit   (v_any),
    .hit_sel   (v_sel)
  );

  assign ev_main_hit  = accept && main_hit;
  assign ev_vict_hit  = accept && !main_hit && v_any;
  assign ev_miss      = accept && !main_hit && !v_any;
  assign ev_fill_done = (state == ST_FILL) && mem_ack;
  assign ev_complete  = ev_main_hit || ev_vict_hit || ev_fill_done;

  assign need_wb = m_valid[cur_idx] && (v_count == CNT_W'(VICT_N)) && v_dirty[0];

  vc_victim_store #(
    .N(VICT_N), .LA_W(LA_W), .LINE_W(LINE_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_swap   (ev_vict_hit),
    .do_fill   (ev_fill_done),
    .sel       (v_sel),
    .in_valid  (m_valid[cur_idx]),
    .in_laddr  ({m_tag[cur_idx], cur_idx}),
    .in_dirty  (m_dirty[cur_idx]),
    .in_data   (m_data[cur_idx]),
    .ent_valid (v_valid),
    .ent_dirty (v_dirty),
    .ent_laddr (v_laddr),
    .ent_data  (v_data),
    .count     (v_count)
  );

  always_comb begin
    if (ev_fill_done) begin
      src_line  = mem_rline;
      src_dirty = 1'b0;
    end else if (ev_vict_hit) begin
      src_line  = v_data[v_sel];
      src_dirty = v_dirty[v_sel];
    end else begin
      src_line  = m_data[cur_idx];
      src_dirty = m_dirty[cur_idx];
    end
    new_line = cur_we ? put_word(src_line, cur_off, cur_wdata) : src_line;
  end

  // ---- memory side: driven from registered state only ----
  assign mem_req_valid = (state != ST_IDLE);
  assign mem_req_we    = (state == ST_WB);
  assign mem_req_addr  = (state == ST_WB) ? v_laddr[0] : f_laddr(p_addr);
  assign mem_wline     = v_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      p_addr     <= '0;
      p_we       <= 1'b0;
      p_wdata    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      m_valid    <= '0;
      m_dirty    <= '0;
      for (int i = 0; i < LINES; i++) begin
        m_tag[i]  <= '0;
        m_data[i] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (ev_miss) begin
          p_addr  <= req_addr;
          p_we    <= req_we;
          p_wdata <= req_wdata;
          state   <= need_wb ? ST_WB : ST_FILL;
        end
        ST_WB:   if (mem_ack) state <= ST_FILL;
        ST_FILL: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (ev_complete) begin
        m_valid[cur_idx] <= 1'b1;
        m_dirty[cur_idx] <= src_dirty || cur_we;
        m_tag[cur_idx]   <= cur_tag;
        m_data[cur_idx]  <= new_line;
        resp_valid       <= 1'b1;
        resp_hit         <= !ev_fill_done;
        resp_rdata       <= get_word(src_line, cur_off);
      end
    end
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int VICT_N = 4,
  parameter int LA_W   = 5,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [LA_W-1:0]   mem_req_addr,
  input logic              mem_ack,
  input logic              ev_main_hit,
  input logic              ev_vict_hit,
  input logic              ev_miss,
  input logic              ev_fill_done,
  input logic [LINES-1:0]  m_valid,
  input logic [TAG_W-1:0]  m_tag [LINES],
  input logic [VICT_N-1:0] v_valid,
  input logic [VICT_N-1:0] v_dirty,
  input logic [LA_W-1:0]   v_laddr [VICT_N],
  input logic [CNT_W-1:0]  v_count
);
  logic             dup;
  logic [IDX_W-1:0] li;
  logic             packed_ok;

  always_comb begin
    dup = 1'b0;
    li  = '0;
    for (int i = 0; i < VICT_N; i++) begin
      li = v_laddr[i][IDX_W-1:0];
      if (v_valid[i] && m_valid[li] && (m_tag[li] == v_laddr[i][LA_W-1:IDX_W]))
        dup = 1'b1;
    end
  end

  // valid entries form a run starting at entry 0
  assign packed_ok = ((v_valid & (v_valid + 1'b1)) == '0);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (m_valid == '0) && (v_valid == '0));

  p_main_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_main_hit |=> resp_valid && resp_hit && !mem_req_valid);

  p_vict_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vict_hit |=> resp_valid && resp_hit && !mem_req_valid);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  p_miss_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !req_ready && mem_req_valid);

  p_fill_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> resp_valid && !resp_hit);

  p_resp_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ev_main_hit || ev_vict_hit || ev_fill_done));

  p_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    packed_ok);

  p_wb_dirty_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |->
      v_valid[0] && v_dirty[0] && (v_count == CNT_W'(VICT_N)));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
endmodule

bind victim_dm_cache vc_checker #(
  .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
  .VICT_N(VICT_N), .LA_W(LA_W), .CNT_W(CNT_W)
) u_vc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_ack       (mem_ack),
  .ev_main_hit   (ev_main_hit),
  .ev_vict_hit   (ev_vict_hit),
  .ev_miss       (ev_miss),
  .ev_fill_done  (ev_fill_done),
  .m_valid       (m_valid),
  .m_tag         (m_tag),
  .v_valid       (v_valid),
  .v_dirty       (v_dirty),
  .v_laddr       (v_laddr),
  .v_count       (v_count)
);

// File: tb/victim_dm_cache_bench.sv
`timescale 1ns/100ps
module victim_dm_cache_bench;
  localparam int WORD_W = 16;
  localparam int OFF_W  = 1;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = 3;
  localparam int VICT_N = 4;
  localparam int ADDR_W = OFF_W + IDX_W + TAG_W;
  localparam int WPL    = 1 << OFF_W;
  localparam int LINE_W = WORD_W * WPL;
  localparam int LA_W   = TAG_W + IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int NWORDS = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              req_ready, resp_valid, resp_hit;
  logic [WORD_W-1:0] resp_rdata;
  logic              mem_req_valid, mem_req_we;
  logic [LA_W-1:0]   mem_req_addr;
  logic [LINE_W-1:0] mem_wline;
  logic              mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rline = '0;

  always #2.5 clk = ~clk;

  victim_dm_cache #(
    .WORD_W(WORD_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .VICT_N(VICT_N)
  ) u_victim_dm_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_wline(mem_wline),
    .mem_ack(mem_ack), .mem_rline(mem_rline)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---- golden data: latest value of every word (R10) ----
  logic [WORD_W-1:0] gold [NWORDS];
  logic [WORD_W-1:0] img  [NWORDS];

  function automatic logic [WORD_W-1:0] init_word(input int a);
    return WORD_W'(32'h5a3c ^ (a * 263));
  endfunction

  // ---- memory responder ----
  int n_rd = 0, n_wr = 0;
  int last_rd_la = -1;

  initial begin
    int dly;
    logic [LA_W-1:0] seen_la;
    logic            seen_we;
    dly = -1;
    seen_la = '0;
    seen_we = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req_valid) begin
        if (dly < 0) begin
          dly = $urandom_range(0, 2);
          seen_la = mem_req_addr;
          seen_we = mem_req_we;
        end
        if (dly == 0) begin
          // R11: request unchanged while waiting for the acknowledge
          chk(mem_req_addr == seen_la && mem_req_we == seen_we, "R11", "request held",
              {mem_req_we, mem_req_addr}, {seen_we, seen_la});
          for (int w = 0; w < WPL; w++) begin
            if (mem_req_we) begin
              img[int'(mem_req_addr) * WPL + w] = mem_wline[w*WORD_W +: WORD_W];
              chk(mem_wline[w*WORD_W +: WORD_W] == gold[int'(mem_req_addr) * WPL + w],
                  "R8", "writeback word", mem_wline[w*WORD_W +: WORD_W],
                  gold[int'(mem_req_addr) * WPL + w]);
            end else begin
              mem_rline[w*WORD_W +: WORD_W] = img[int'(mem_req_addr) * WPL + w];
            end
          end
          if (mem_req_we) n_wr++;
          else begin
            n_rd++;
            last_rd_la = int'(mem_req_addr);
          end
          mem_ack = 1'b1;
          dly = -1;
        end else begin
          dly--;
        end
      end
    end
  end

  // ---- structural model from the requirements ----
  bit mm_v [LINES];
  int mm_t [LINES];
  bit mm_d [LINES];
  int vl_la [VICT_N];
  bit vl_d [VICT_N];
  int vcnt = 0;

  task automatic vl_remove(input int j);
    for (int k = j; k < vcnt - 1; k++) begin
      vl_la[k] = vl_la[k+1];
      vl_d[k]  = vl_d[k+1];
    end
    vcnt--;
  endtask

  task automatic vl_append(input int la, input bit d);
    vl_la[vcnt] = la;
    vl_d[vcnt]  = d;
    vcnt++;
  endtask

  // kind: 0 main hit, 1 victim hit, 2 miss
  task automatic model_step(input bit we, input int addr, output int kind, output bit wb);
    int idx, tag, la, j;
    idx = (addr >> OFF_W) % LINES;
    tag = addr >> (OFF_W + IDX_W);
    la  = addr >> OFF_W;
    wb  = 0;
    j   = -1;
    for (int k = 0; k < vcnt; k++) if (vl_la[k] == la) j = k;
    if (mm_v[idx] && mm_t[idx] == tag) begin
      kind = 0;
      if (we) mm_d[idx] = 1;
    end else if (j >= 0) begin
      bit vd;
      kind = 1;
      vd = vl_d[j];
      vl_remove(j);
      if (mm_v[idx]) vl_append(mm_t[idx] * LINES + idx, mm_d[idx]);
      mm_v[idx] = 1; mm_t[idx] = tag; mm_d[idx] = vd | we;
    end else begin
      kind = 2;
      if (mm_v[idx]) begin
        if (vcnt == VICT_N) begin
          wb = vl_d[0];
          vl_remove(0);
        end
        vl_append(mm_t[idx] * LINES + idx, mm_d[idx]);
      end
      mm_v[idx] = 1; mm_t[idx] = tag; mm_d[idx] = we;
    end
  endtask

  function automatic int mk(input int tag, input int idx, input int off);
    return (tag << (OFF_W + IDX_W)) | (idx << OFF_W) | off;
  endfunction

  task automatic do_req(input bit we, input int addr, input logic [WORD_W-1:0] wd);
    int kind, cyc, rd0, wr0;
    bit ewb;
    string rq;
    model_step(we, addr, kind, ewb);
    rq = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R6";
    rd0 = n_rd;
    wr0 = n_wr;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = ADDR_W'(addr);
    req_wdata = wd;
    if (we) gold[addr] = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (kind == 2) chk(req_ready == 1'b0, "R6", "stall after miss", req_ready, 0);
    while (!resp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(resp_valid == 1'b1, rq, "response arrives", resp_valid, 1);
    if (kind != 2) chk(cyc == 1, rq, "hit latency", cyc, 1);
    chk(resp_hit == (kind != 2), rq, "hit flag", resp_hit, (kind != 2));
    if (!we) chk(resp_rdata == gold[addr], "R10", "read data", resp_rdata, gold[addr]);
    chk((n_rd - rd0) == int'(kind == 2), rq, "line reads", n_rd - rd0, (kind == 2));
    if (kind == 2)
      chk(last_rd_la == (addr >> OFF_W), "R2", "refill line address", last_rd_la, addr >> OFF_W);
    chk((n_wr - wr0) == int'(ewb), ewb ? "R8" : "R9", "writebacks", n_wr - wr0, ewb);
  endtask

  initial begin
    for (int a = 0; a < NWORDS; a++) begin
      gold[a] = init_word(a);
      img[a]  = init_word(a);
    end
    for (int i = 0; i < LINES; i++) begin
      mm_v[i] = 0; mm_t[i] = 0; mm_d[i] = 0;
    end
  end

  // watchdog
  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "no memory request after reset", mem_req_valid, 0);

    // directed: first access misses (R1), then main hits (R3)
    do_req(0, mk(0, 0, 0), '0);                 // R1 miss
    do_req(0, mk(0, 0, 1), '0);                 // R3 hit, other word of line
    do_req(1, mk(0, 0, 1), 16'hbeef);           // R3 write hit, dirty
    do_req(0, mk(1, 0, 0), '0);                 // R7 conflict pushes line 0 to victim
    do_req(0, mk(0, 0, 1), '0);                 // R4 swap back, data kept (R10)
    do_req(0, mk(1, 0, 1), '0);                 // R4 the other line now in victim
    // fill the victim buffer so the dirty line ages out (R8)
    for (int t = 2; t < 7; t++) do_req(0, mk(t, 0, 0), '0);
    do_req(0, mk(0, 0, 1), '0);                 // R10 value returned from memory
    // write miss allocates (R10), clean evictions (R9)
    do_req(1, mk(5, 3, 0), 16'h1234);
    do_req(0, mk(5, 3, 0), '0);

    // constrained random: whole small address space, about one third writes
    for (int n = 0; n < 3000; n++) begin
      bit we;
      we = ($urandom_range(0, 2) == 0);
      do_req(we, int'($urandom_range(0, NWORDS - 1)), WORD_W'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule